// File: doc/BRIEF.md
# Fast-Domain FIFO with Polled Read Crossing

A first-in first-out buffer whose storage, both pointers and the occupancy counter all sit in the faster write clock domain. Words enter on the fast clock whenever the write enable is high. A slower, unrelated clock domain takes words out by polling. It raises a single read request, and the request crosses into the fast domain as one synchronized toggle. The fast side pops exactly one word into a holding register and sends a response toggle back. The slow side then presents that word, together with a flag that says the FIFO was empty, on a one-cycle valid pulse.

Because no pointer ever crosses between domains, no Gray-coded counter is needed. Only one control bit crosses in each direction, and each is passed through two flops in the destination domain before any use. The full flag rises early, a configurable margin below the true capacity, which leaves the producer room to react. Both clocks must run continuously. Flow is controlled only by the enables.

Top module: `fast_side_fifo`

## Requirements
- R1: Words of DATA_W bits (default 9) leave through the slow-side read port in the order they were written, including across pointer wrap after more than DEPTH (default 16) writes.
- R2: A write is accepted on a fast clock edge when wr_en_i is high and occupancy is below DEPTH. A write at occupancy DEPTH is ignored and changes neither the count nor the stored words.
- R3: Occupancy rises by one on an accepted write without a pop, falls by one on a pop without a write, and holds when both or neither occur.
- R4: full_o is high exactly when occupancy is at least DEPTH-MARGIN (default 12). full_o is combinational from the occupancy register, so it reflects a write in the cycle after that write's edge.
- R5: empty_o is high exactly when occupancy is zero.
- R6: rd_req_i sampled high on a slow clock edge while rd_busy_o is low starts a read. rd_busy_o is high from the following slow cycle until the response arrives.
- R7: rd_req_i sampled while rd_busy_o is high is ignored: no second toggle is sent, and no word is popped for it.
- R8: A response raises rd_valid_o for exactly one slow cycle. rd_data_o and rd_empty_o change only in that cycle and hold their values until the next response.
- R9: A read issued while the FIFO is empty returns rd_empty_o=1 and pops nothing. When a word was popped, rd_empty_o=0.
- R10: While rst_ni is low: empty_o=1, full_o=0, rd_busy_o=0, rd_valid_o=0, rd_empty_o=1, rd_data_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast_i | input | 1 | Fast (write) clock; holds storage and counters |
| clk_slow_i | input | 1 | Slow (read) clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| wr_en_i | input | 1 | Write enable, fast domain |
| wr_data_i | input | DATA_W | Write word |
| full_o | output | 1 | Early-full flag, fast domain |
| empty_o | output | 1 | Empty flag, fast domain |
| rd_req_i | input | 1 | Read request, slow domain |
| rd_busy_o | output | 1 | Request outstanding, slow domain |
| rd_valid_o | output | 1 | One-cycle response strobe, slow domain |
| rd_data_o | output | DATA_W | Word returned by the last response |
| rd_empty_o | output | 1 | Last response found the FIFO empty |

## Verification
The checker takes for granted that wr_en_i stays low while rst_ni is asserted, and that both clocks keep running. It also relies on the fact that the response data is stable in the fast holding register before the response toggle can be seen on the slow side. The stimulus changes inputs only on falling edges and keeps wr_en_i low throughout reset. It deliberately drives writes past capacity, requests while busy and reads from an empty FIFO, so the guarded paths are exercised rather than avoided. A concurrent phase keeps writes flowing while a read crosses, so that a simultaneous push and pop occurs.

// File: rtl/fsf_pkg.sv
package fsf_pkg;
  parameter int unsigned DATA_W_DEF = 9;
  parameter int unsigned DEPTH_DEF  = 16;
  parameter int unsigned MARGIN_DEF = 4;

  typedef enum logic {
    SLOT_IDLE = 1'b0,
    SLOT_WAIT = 1'b1
  } slot_state_e;
endpackage

// File: rtl/fsf_sync2.sv
module fsf_sync2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/fsf_store.sv
module fsf_store #(
  parameter int unsigned DATA_W = fsf_pkg::DATA_W_DEF,
  parameter int unsigned DEPTH  = fsf_pkg::DEPTH_DEF,
  parameter int unsigned MARGIN = fsf_pkg::MARGIN_DEF,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              pop_req_i,
  output logic [DATA_W-1:0] head_o,
  output logic [CNT_W-1:0]  occ_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              push_o,
  output logic              pop_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  occ_q;

  assign empty_o = (occ_q == '0);
  assign full_o  = (occ_q >= CNT_W'(DEPTH - MARGIN));
  assign push_o  = wr_en_i && (occ_q != CNT_W'(DEPTH));
  assign pop_o   = pop_req_i && !empty_o;
  assign head_o  = mem_q[rd_ptr_q];
  assign occ_o   = occ_q;

  always_ff @(posedge clk_i) begin
    if (push_o) mem_q[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
    end else begin
      if (push_o) wr_ptr_q <= wr_ptr_q + 1'b1;  // wraps modulo DEPTH
      if (pop_o)  rd_ptr_q <= rd_ptr_q + 1'b1;
      if (push_o && !pop_o)      occ_q <= occ_q + 1'b1;
      else if (pop_o && !push_o) occ_q <= occ_q - 1'b1;
    end
  end
endmodule

// File: rtl/fsf_fast_port.sv
module fsf_fast_port #(
  parameter int unsigned DATA_W = fsf_pkg::DATA_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_tgl_i,
  input  logic [DATA_W-1:0] head_i,
  input  logic              empty_i,
  output logic              pop_req_o,
  output logic              resp_tgl_o,
  output logic [DATA_W-1:0] resp_data_o,
  output logic              resp_empty_o
);
  logic req_s, req_d_q, resp_tgl_q, resp_empty_q;
  logic [DATA_W-1:0] resp_data_q;

  fsf_sync2 u_req_sync (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(req_tgl_i), .q_o(req_s));

  assign pop_req_o = req_s ^ req_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_d_q      <= 1'b0;
      resp_tgl_q   <= 1'b0;
      resp_empty_q <= 1'b1;
      resp_data_q  <= '0;
    end else begin
      req_d_q <= req_s;
      if (pop_req_o) begin
        resp_empty_q <= empty_i;
        if (!empty_i) resp_data_q <= head_i;
        resp_tgl_q <= ~resp_tgl_q;  // data settles with toggle, seen two slow edges later
      end
    end
  end

  assign resp_tgl_o   = resp_tgl_q;
  assign resp_data_o  = resp_data_q;
  assign resp_empty_o = resp_empty_q;
endmodule

// File: rtl/fsf_slow_port.sv
module fsf_slow_port #(
  parameter int unsigned DATA_W = fsf_pkg::DATA_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_req_i,
  input  logic              resp_tgl_i,
  input  logic [DATA_W-1:0] resp_data_i,
  input  logic              resp_empty_i,
  output logic              req_tgl_o,
  output logic              rd_busy_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_empty_o
);
  import fsf_pkg::*;

  slot_state_e state_q;
  logic req_tgl_q, resp_s, resp_d_q, valid_q, empty_q;
  logic [DATA_W-1:0] data_q;
  logic resp_edge;

  fsf_sync2 u_resp_sync (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(resp_tgl_i), .q_o(resp_s));

  assign resp_edge = resp_s ^ resp_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SLOT_IDLE;
      req_tgl_q <= 1'b0;
      resp_d_q  <= 1'b0;
      valid_q   <= 1'b0;
      empty_q   <= 1'b1;
      data_q    <= '0;
    end else begin
      resp_d_q <= resp_s;
      valid_q  <= 1'b0;
      case (state_q)
        SLOT_IDLE: if (rd_req_i) begin
          req_tgl_q <= ~req_tgl_q;
          state_q   <= SLOT_WAIT;
        end
        SLOT_WAIT: if (resp_edge) begin
          data_q  <= resp_data_i;
          empty_q <= resp_empty_i;
          valid_q <= 1'b1;
          state_q <= SLOT_IDLE;
        end
        default: state_q <= SLOT_IDLE;
      endcase
    end
  end

  assign req_tgl_o  = req_tgl_q;
  assign rd_busy_o  = (state_q == SLOT_WAIT);
  assign rd_valid_o = valid_q;
  assign rd_data_o  = data_q;
  assign rd_empty_o = empty_q;
endmodule

// File: rtl/fast_side_fifo.sv
module fast_side_fifo #(
  parameter int unsigned DATA_W = fsf_pkg::DATA_W_DEF,
  parameter int unsigned DEPTH  = fsf_pkg::DEPTH_DEF,
  parameter int unsigned MARGIN = fsf_pkg::MARGIN_DEF
) (
  input  logic              clk_fast_i,
  input  logic              clk_slow_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              full_o,
  output logic              empty_o,
  input  logic              rd_req_i,
  output logic              rd_busy_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_empty_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1;

  logic [DATA_W-1:0] head_w, resp_data_w;
  logic [CNT_W-1:0]  occ_w;
  logic push_w, pop_w, pop_req_w, req_tgl_w, resp_tgl_w, resp_empty_w;

  fsf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .MARGIN(MARGIN)) u_store (
    .clk_i(clk_fast_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .pop_req_i(pop_req_w), .head_o(head_w), .occ_o(occ_w), .full_o(full_o),
    .empty_o(empty_o), .push_o(push_w), .pop_o(pop_w)
  );

  fsf_fast_port #(.DATA_W(DATA_W)) u_fast (
    .clk_i(clk_fast_i), .rst_ni(rst_ni), .req_tgl_i(req_tgl_w), .head_i(head_w),
    .empty_i(empty_o), .pop_req_o(pop_req_w), .resp_tgl_o(resp_tgl_w),
    .resp_data_o(resp_data_w), .resp_empty_o(resp_empty_w)
  );

  fsf_slow_port #(.DATA_W(DATA_W)) u_slow (
    .clk_i(clk_slow_i), .rst_ni(rst_ni), .rd_req_i(rd_req_i), .resp_tgl_i(resp_tgl_w),
    .resp_data_i(resp_data_w), .resp_empty_i(resp_empty_w), .req_tgl_o(req_tgl_w),
    .rd_busy_o(rd_busy_o), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .rd_empty_o(rd_empty_o)
  );
endmodule

// File: rtl/fast_side_fifo_chk.sv
module fast_side_fifo_chk #(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned CNT_W  = 5
) (
  input logic              clk_fast_i,
  input logic              clk_slow_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              push_i,
  input logic              pop_i,
  input logic [CNT_W-1:0]  occ_i,
  input logic              empty_i,
  input logic              rd_req_i,
  input logic              rd_busy_i,
  input logic              rd_valid_i,
  input logic [DATA_W-1:0] rd_data_i,
  input logic              rd_empty_i
);
  always_ff @(posedge clk_fast_i) begin
    if (!rst_ni) AST_EN_IDLE_RST: assert (!wr_en_i);  // R10
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_fast_i) disable iff (!rst_ni)
    (occ_i == CNT_W'(DEPTH)) |-> !push_i);  // R2
  AST_CNT_UP: assert property (@(posedge clk_fast_i) disable iff (!rst_ni)
    (push_i && !pop_i) |=> (occ_i == $past(occ_i) + 1'b1));  // R3
  AST_CNT_DOWN: assert property (@(posedge clk_fast_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> (occ_i == $past(occ_i) - 1'b1));  // R3
  AST_CNT_HOLD: assert property (@(posedge clk_fast_i) disable iff (!rst_ni)
    (push_i == pop_i) |=> $stable(occ_i));  // R3
  AST_NO_POP_EMPTY: assert property (@(posedge clk_fast_i) disable iff (!rst_ni)
    pop_i |-> !empty_i);  // R9
  AST_BUSY_SET: assert property (@(posedge clk_slow_i) disable iff (!rst_ni)
    (rd_req_i && !rd_busy_i) |=> rd_busy_i);  // R6
  AST_VALID_PULSE: assert property (@(posedge clk_slow_i) disable iff (!rst_ni)
    rd_valid_i |=> !rd_valid_i);  // R8
  AST_DATA_HELD: assert property (@(posedge clk_slow_i) disable iff (!rst_ni)
    !(rd_valid_i) |-> ##0 1'b1 ##1 (rd_valid_i || ($stable(rd_data_i) && $stable(rd_empty_i))));  // R8
endmodule

bind fast_side_fifo fast_side_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_fast_i(clk_fast_i), .clk_slow_i(clk_slow_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
  .push_i(push_w), .pop_i(pop_w), .occ_i(occ_w), .empty_i(empty_o), .rd_req_i(rd_req_i),
  .rd_busy_i(rd_busy_o), .rd_valid_i(rd_valid_o), .rd_data_i(rd_data_o),
  .rd_empty_i(rd_empty_o)
);

// File: tb/fast_side_fifo_tb.sv
`timescale 1ns/1ps
module fast_side_fifo_tb;
  localparam int DW = 9, DEPTH = 16, MARGIN = 4;

  logic clk_f = 1'b0, clk_s = 1'b0, rst_ni = 1'b0;
  logic wr_en = 1'b0, rd_req = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic full_o, empty_o, rd_busy_o, rd_valid_o, rd_empty_o;
  logic [DW-1:0] rd_data_o;

  int total = 0, bad = 0;
  logic [DW-1:0] model[$];

  always #2.5 clk_f = ~clk_f;
  always #6.5 clk_s = ~clk_s;

  fast_side_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .MARGIN(MARGIN)) u_dut (
    .clk_fast_i(clk_f), .clk_slow_i(clk_s), .rst_ni(rst_ni), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .full_o(full_o), .empty_o(empty_o), .rd_req_i(rd_req),
    .rd_busy_o(rd_busy_o), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .rd_empty_o(rd_empty_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push_word(input logic [DW-1:0] v, input bit flags);
    @(negedge clk_f);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk_f);
    wr_en = 1'b0;
    if (model.size() < DEPTH) model.push_back(v);  // R2 beyond capacity ignored
    if (flags) begin
      chk("R4 full_o", full_o, int'(model.size() >= DEPTH - MARGIN));
      chk("R5 empty_o", empty_o, int'(model.size() == 0));
    end
  endtask

  // hold_cycles > 1 issues extra requests while busy (R7)
  task automatic do_read(input int hold_cycles);
    bit got = 0;
    @(negedge clk_s);
    rd_req = 1'b1;
    for (int i = 0; i < hold_cycles; i++) begin
      @(negedge clk_s);
      if (i == 0) chk("R6 busy after request", rd_busy_o, 1);
    end
    rd_req = 1'b0;
    for (int i = 0; i < 40 && !got; i++) begin
      if (rd_valid_o) got = 1;
      else @(negedge clk_s);
    end
    chk("R8 response valid", got, 1);
    chk("R6 busy cleared", rd_busy_o, 0);
    if (model.size() == 0) begin
      chk("R9 empty response", rd_empty_o, 1);
    end else begin
      chk("R9 nonempty response", rd_empty_o, 0);
      chk("R1 order", rd_data_o, model.pop_front());
    end
    @(negedge clk_s);
    chk("R8 valid one cycle", rd_valid_o, 0);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] last;
    #20;
    chk("R10 empty_o", empty_o, 1);
    chk("R10 full_o", full_o, 0);
    chk("R10 rd_busy_o", rd_busy_o, 0);
    chk("R10 rd_valid_o", rd_valid_o, 0);
    chk("R10 rd_empty_o", rd_empty_o, 1);
    chk("R10 rd_data_o", rd_data_o, 0);
    #3 rst_ni = 1'b1;

    // fill sweep past capacity, drain past empty; two rounds cover wrap
    for (int r = 0; r < 2; r++) begin
      for (int k = 0; k < DEPTH + 2; k++)
        push_word(DW'((k * 37 + r * 101 + 5) % 512), 1'b1);
      chk("R2 capacity hold full", full_o, 1);
      for (int k = 0; k < DEPTH + 1; k++) do_read(1);
      @(negedge clk_f);
      chk("R5 empty after drain", empty_o, 1);
      chk("R4 full after drain", full_o, 0);
    end

    // held response after empty read (R8)
    last = rd_data_o;
    repeat (5) @(negedge clk_s);
    chk("R8 data held", rd_data_o, last);

    // requests while busy are ignored (R7)
    for (int k = 0; k < 3; k++) push_word(DW'(9'h1A0 + k), 1'b1);
    do_read(3);
    do_read(1);
    do_read(1);
    do_read(1);
    @(negedge clk_f);
    chk("R7 no extra pop", empty_o, 1);

    // writes streaming while a read crosses (R3)
    push_word(9'h011, 1'b1);
    push_word(9'h022, 1'b1);
    fork
      for (int k = 0; k < 10; k++) push_word(DW'(9'h100 + k), 1'b0);
      do_read(1);
    join
    @(negedge clk_f);
    chk("R3 count 11 not full", full_o, 0);
    push_word(9'h1FF, 1'b0);
    chk("R3 count 12 full", full_o, 1);
    while (model.size() > 0) do_read(1);
    do_read(1);
    @(negedge clk_f);
    chk("R5 final empty", empty_o, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule